// File: doc/BRIEF.md
# UART Interrupt Source Combiner

This block gathers the four interrupt causes of one UART channel (receive, error, transmit, modem) into a single level-sensitive interrupt line. Event pulses from the surrounding UART logic are latched into a sticky source register. A mask register hides individual causes. The pending view is the set of latched causes that are not masked. Software reaches all three registers through a small single-cycle register port. Writing the source or pending register with a bit pattern acknowledges those causes.

The block also generates the transmit cause by itself. While the transmit FIFO is enabled, it compares the FIFO fill count against a programmable threshold. That threshold is a 3-bit level code multiplied by a scale that depends on the static channel number. The FIFOs, baud timing and serial framing live outside the block. It also publishes the transmit fill count and a full flag in a status word.

Top module: `uart_irq_agg`

## Requirements
- R1: After reset the source, pending and mask registers read zero, irq_o is low and reads return 0.
- R2: Cause bits are receive = bit 0, error = bit 1, transmit = bit 2, modem = bit 3. A one on evt_i[k] sets source bit k from the next cycle on, and it stays set until acknowledged.
- R3: Reading address 1 returns pending = source & ~mask. irq_o is high exactly when pending is non-zero.
- R4: A write to address 1 clears, in the source register, every bit that is one in the written value. Pending loses those bits with it.
- R5: A write to address 0 clears the source bits that are one in the written value. Bits written as zero keep their value. Reading address 0 returns the source register.
- R6: A write to address 2 loads the mask, and reading address 2 returns it. Pending and irq_o follow the new mask from the next cycle.
- R7: The transmit threshold is tx_lvl_i times a scale. The scale is 32 for channel 0, 8 for channels 1 and 4, and 2 for channels 2 and 3. Any other channel number gives a threshold of 0.
- R8: While fifo_en_i is 1 and tx_count_i is at or below the threshold, source bit 2 is set every cycle. While fifo_en_i is 0, the transmit bit is set only by evt_i[2].
- R9: status_o[23:16] equals tx_count_i. status_o[24] is 1 when tx_count_i >= TX_DEPTH. All other status bits are 0.
- R10: An event, or the transmit threshold condition, present in the same cycle as an acknowledging write leaves its bit set.
- R11: Address 3 reads 0, and a write to it changes no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| evt_i | input | 4 | Cause event pulses, one per source bit |
| fifo_en_i | input | 1 | Transmit FIFO enabled |
| tx_lvl_i | input | 3 | Transmit threshold level code |
| tx_count_i | input | 8 | Transmit FIFO fill count |
| reg_we_i | input | 1 | Register write strobe |
| reg_addr_i | input | 2 | Register address: 0 source, 1 pending, 2 mask |
| reg_wdata_i | input | 4 | Register write data |
| reg_rdata_o | output | 4 | Register read data for reg_addr_i, combinational |
| status_o | output | 32 | Transmit count and full flag |
| irq_o | output | 1 | Combined interrupt line |

## Verification
A corrupted source or mask bit appears on irq_o in the very cycle the bad state exists, whenever that bit is unmasked. It also appears on the read port as soon as the register is addressed. The bench therefore compares irq_o and the addressed register against a reference model in every cycle. A wrong threshold scale or comparison only shows through bit 2 of the source register. To catch it, the transmit bit is acknowledged and then re-read one cycle later, on instances built for several channel numbers. A lost event under a simultaneous acknowledge shows one cycle after that write.

// File: rtl/uart_irq_pkg.sv
`timescale 1ns/1ps
package uart_irq_pkg;
  localparam int unsigned NSRC    = 4;
  localparam int unsigned SRC_RX  = 0;
  localparam int unsigned SRC_ERR = 1;
  localparam int unsigned SRC_TX  = 2;
  localparam int unsigned SRC_MDM = 3;
  localparam int unsigned CNT_W   = 8;
  localparam int unsigned LVL_W   = 3;
  localparam int unsigned THR_W   = 9;
  localparam int unsigned ADDR_W  = 2;

  typedef enum logic [ADDR_W-1:0] {
    ADDR_SRC  = 2'd0,
    ADDR_PEND = 2'd1,
    ADDR_MASK = 2'd2,
    ADDR_NONE = 2'd3
  } reg_addr_e;

  function automatic int unsigned chan_scale(input int unsigned ch);
    case (ch)
      0:       return 32;
      1, 4:    return 8;
      2, 3:    return 2;
      default: return 0;
    endcase
  endfunction
endpackage

// File: rtl/uart_irq_txtrig.sv
`timescale 1ns/1ps
module uart_irq_txtrig
  import uart_irq_pkg::*;
#(
  parameter int unsigned CHANNEL = 1
) (
  input  logic             fifo_en_i,
  input  logic [LVL_W-1:0] tx_lvl_i,
  input  logic [CNT_W-1:0] tx_count_i,
  output logic [THR_W-1:0] thr_o,
  output logic             tx_set_o
);
  localparam int unsigned SCALE = chan_scale(CHANNEL);

  generate
    if (SCALE == 0) begin : g_zero
      assign thr_o = '0;
    end else begin : g_scaled
      assign thr_o = THR_W'(tx_lvl_i) * THR_W'(SCALE);
    end
  endgenerate

  assign tx_set_o = fifo_en_i && (THR_W'(tx_count_i) <= thr_o);
endmodule

// File: rtl/uart_irq_srcreg.sv
`timescale 1ns/1ps
module uart_irq_srcreg
  import uart_irq_pkg::*;
(
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic [NSRC-1:0] evt_i,
  input  logic            tx_set_i,
  input  logic            clr_en_i,
  input  logic [NSRC-1:0] clr_mask_i,
  output logic [NSRC-1:0] src_o
);
  logic [NSRC-1:0] src_q, set_vec, clr_vec;

  always_comb begin
    set_vec         = evt_i;
    set_vec[SRC_TX] = evt_i[SRC_TX] | tx_set_i;
    clr_vec         = clr_en_i ? clr_mask_i : '0;
  end

  // set wins over acknowledge
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) src_q <= '0;
    else         src_q <= (src_q & ~clr_vec) | set_vec;
  end

  assign src_o = src_q;

  a_r10_event_sets: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|evt_i) |=> ((src_q & $past(evt_i)) == $past(evt_i)));

  a_r5_ack_clears: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_en_i |=> ((src_q & $past(clr_mask_i & ~set_vec)) == '0));

  a_r2_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !clr_en_i |=> ((src_q & $past(src_q)) == $past(src_q)));
endmodule

// File: rtl/uart_irq_regif.sv
`timescale 1ns/1ps
module uart_irq_regif
  import uart_irq_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [NSRC-1:0]   wdata_i,
  input  logic [NSRC-1:0]   src_i,
  input  logic [NSRC-1:0]   pend_i,
  output logic [NSRC-1:0]   mask_o,
  output logic              clr_en_o,
  output logic [NSRC-1:0]   clr_mask_o,
  output logic [NSRC-1:0]   rdata_o
);
  reg_addr_e       addr;
  logic [NSRC-1:0] mask_q;

  assign addr       = reg_addr_e'(addr_i);
  assign clr_en_o   = we_i && (addr == ADDR_SRC || addr == ADDR_PEND);
  assign clr_mask_o = wdata_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                          mask_q <= '0;
    else if (we_i && addr == ADDR_MASK)   mask_q <= wdata_i;
  end

  always_comb begin
    case (addr)
      ADDR_SRC:  rdata_o = src_i;
      ADDR_PEND: rdata_o = pend_i;
      ADDR_MASK: rdata_o = mask_q;
      default:   rdata_o = '0;
    endcase
  end

  assign mask_o = mask_q;

  a_r6_mask_load: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (we_i && addr == ADDR_MASK) |=> (mask_q == $past(wdata_i)));

  a_r11_mask_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(we_i && addr == ADDR_MASK) |=> $stable(mask_q));
endmodule

// File: rtl/uart_irq_agg.sv
`timescale 1ns/1ps
module uart_irq_agg
  import uart_irq_pkg::*;
#(
  parameter int unsigned CHANNEL  = 1,
  parameter int unsigned TX_DEPTH = 64
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [NSRC-1:0]   evt_i,
  input  logic              fifo_en_i,
  input  logic [LVL_W-1:0]  tx_lvl_i,
  input  logic [CNT_W-1:0]  tx_count_i,
  input  logic              reg_we_i,
  input  logic [ADDR_W-1:0] reg_addr_i,
  input  logic [NSRC-1:0]   reg_wdata_i,
  output logic [NSRC-1:0]   reg_rdata_o,
  output logic [31:0]       status_o,
  output logic              irq_o
);
  localparam int unsigned CNT_LSB = 16;
  localparam int unsigned FULL_BIT = CNT_LSB + CNT_W;

  logic [THR_W-1:0] thr;
  logic             tx_set, clr_en;
  logic [NSRC-1:0]  src, mask, pend, clr_mask;

  uart_irq_txtrig #(.CHANNEL(CHANNEL)) u_trig (
    .fifo_en_i (fifo_en_i),
    .tx_lvl_i  (tx_lvl_i),
    .tx_count_i(tx_count_i),
    .thr_o     (thr),
    .tx_set_o  (tx_set)
  );

  uart_irq_srcreg u_src (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .evt_i     (evt_i),
    .tx_set_i  (tx_set),
    .clr_en_i  (clr_en),
    .clr_mask_i(clr_mask),
    .src_o     (src)
  );

  assign pend = src & ~mask;

  uart_irq_regif u_regif (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .we_i      (reg_we_i),
    .addr_i    (reg_addr_i),
    .wdata_i   (reg_wdata_i),
    .src_i     (src),
    .pend_i    (pend),
    .mask_o    (mask),
    .clr_en_o  (clr_en),
    .clr_mask_o(clr_mask),
    .rdata_o   (reg_rdata_o)
  );

  assign irq_o = |pend;

  always_comb begin
    status_o                          = '0;
    status_o[CNT_LSB +: CNT_W]        = tx_count_i;
    status_o[FULL_BIT]                = (32'(tx_count_i) >= TX_DEPTH);
  end

  a_r8_tx_level: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fifo_en_i && THR_W'(tx_count_i) <= thr) |=> src[SRC_TX]);

  a_r3_masked_quiet: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((src & ~mask) == '0) |-> !irq_o);

  a_r1_reset_clear: assert property (@(posedge clk_i)
    $rose(rst_ni) |-> (src == '0 && mask == '0));
endmodule

// File: tb/uart_irq_agg_test.sv
`timescale 1ns/1ps
module uart_irq_agg_test;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [3:0] evt = '0;
  logic       fen = 1'b0;
  logic [2:0] lvl = '0;
  logic [7:0] cnt = '0;
  logic       we = 1'b0;
  logic [1:0] addr = '0;
  logic [3:0] wd = '0;
  logic [3:0] rd, rd_c0, rd_c2, rd_c7;
  logic [31:0] st, st_c0, st_c2, st_c7;
  logic       irq, irq_c0, irq_c2, irq_c7;

  int checks = 0;
  int errors = 0;
  logic [3:0] m_src = '0;
  logic [3:0] m_mask = '0;

  always #10 clk = ~clk;

  uart_irq_agg #(.CHANNEL(1), .TX_DEPTH(64)) uut (
    .clk_i(clk), .rst_ni(rst_n), .evt_i(evt), .fifo_en_i(fen), .tx_lvl_i(lvl),
    .tx_count_i(cnt), .reg_we_i(we), .reg_addr_i(addr), .reg_wdata_i(wd),
    .reg_rdata_o(rd), .status_o(st), .irq_o(irq));
  uart_irq_agg #(.CHANNEL(0)) uut_c0 (
    .clk_i(clk), .rst_ni(rst_n), .evt_i(evt), .fifo_en_i(fen), .tx_lvl_i(lvl),
    .tx_count_i(cnt), .reg_we_i(we), .reg_addr_i(addr), .reg_wdata_i(wd),
    .reg_rdata_o(rd_c0), .status_o(st_c0), .irq_o(irq_c0));
  uart_irq_agg #(.CHANNEL(2)) uut_c2 (
    .clk_i(clk), .rst_ni(rst_n), .evt_i(evt), .fifo_en_i(fen), .tx_lvl_i(lvl),
    .tx_count_i(cnt), .reg_we_i(we), .reg_addr_i(addr), .reg_wdata_i(wd),
    .reg_rdata_o(rd_c2), .status_o(st_c2), .irq_o(irq_c2));
  uart_irq_agg #(.CHANNEL(7)) uut_c7 (
    .clk_i(clk), .rst_ni(rst_n), .evt_i(evt), .fifo_en_i(fen), .tx_lvl_i(lvl),
    .tx_count_i(cnt), .reg_we_i(we), .reg_addr_i(addr), .reg_wdata_i(wd),
    .reg_rdata_o(rd_c7), .status_o(st_c7), .irq_o(irq_c7));

  function automatic int exp_thr(input int ch, input int l);
    case (ch)
      0:       return l * 32;
      1, 4:    return l * 8;
      2, 3:    return l * 2;
      default: return 0;
    endcase
  endfunction

  function automatic logic [3:0] exp_rd(input logic [1:0] a);
    case (a)
      2'd0:    return m_src;
      2'd1:    return m_src & ~m_mask;
      2'd2:    return m_mask;
      default: return 4'h0;
    endcase
  endfunction

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // drive one cycle, check outputs of the current state, advance the model
  task automatic step(input string tag, input logic [3:0] e, input logic w,
                      input logic [1:0] a, input logic [3:0] d, input logic en,
                      input logic [2:0] l, input logic [7:0] c);
    logic [3:0] clr;
    logic       trig;
    @(negedge clk);
    evt = e; we = w; addr = a; wd = d; fen = en; lvl = l; cnt = c;
    #1;
    check(tag, {28'h0, rd}, {28'h0, exp_rd(a)});
    check("R3 irq", {31'h0, irq}, {31'h0, |(m_src & ~m_mask)});
    check("R9 status", st, {7'h0, (int'(c) >= 64), c, 16'h0});
    clr  = (w && a < 2'd2) ? d : 4'h0;
    trig = en && (int'(c) <= exp_thr(1, int'(l)));
    m_src = (m_src & ~clr) | e | {1'b0, trig, 2'b00};
    if (w && a == 2'd2) m_mask = d;
  endtask

  // R7: acknowledge bit 2 under a threshold condition, read it back next cycle
  task automatic probe(input logic en, input logic [2:0] l, input logic [7:0] c);
    step("R7 probe", 4'h0, 1'b1, 2'd0, 4'h4, en, l, c);
    step("R7 readback", 4'h0, 1'b0, 2'd0, 4'h0, 1'b0, 3'd0, 8'd0);
    check("R7 ch0", {31'h0, rd_c0[2]}, {31'h0, en && int'(c) <= exp_thr(0, int'(l))});
    check("R7 ch2", {31'h0, rd_c2[2]}, {31'h0, en && int'(c) <= exp_thr(2, int'(l))});
    check("R7 ch7", {31'h0, rd_c7[2]}, {31'h0, en && int'(c) <= exp_thr(7, int'(l))});
  endtask

  initial begin
    #(20 * 150000);
    errors++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic [31:0] seed;
    seed = 32'd4242;
    void'($urandom(seed));
    #35;
    for (int a = 0; a < 4; a++) begin
      addr = 2'(a); #1;
      check("R1 reset read", {28'h0, rd}, 32'h0);
    end
    check("R1 reset irq", {31'h0, irq}, 32'h0);
    rst_n = 1'b1;

    // R2 each cause bit, then acknowledge via address 0 (R5)
    for (int k = 0; k < 4; k++) begin
      step("R2 pulse", 4'(1 << k), 1'b0, 2'd0, 4'h0, 1'b0, 3'd0, 8'd0);
      step("R2 bit position", 4'h0, 1'b1, 2'd0, 4'(1 << k), 1'b0, 3'd0, 8'd0);
    end
    // R5 partial acknowledge
    step("R2 set all", 4'hF, 1'b0, 2'd0, 4'h0, 1'b0, 3'd0, 8'd0);
    step("R5 partial ack", 4'h0, 1'b1, 2'd0, 4'h5, 1'b0, 3'd0, 8'd0);
    step("R5 keep zeros", 4'h0, 1'b0, 2'd0, 4'h0, 1'b0, 3'd0, 8'd0);
    // R6 mask, R3 pending view
    step("R6 mask write", 4'h0, 1'b1, 2'd2, 4'hA, 1'b0, 3'd0, 8'd0);
    step("R6 mask read", 4'h0, 1'b0, 2'd2, 4'h0, 1'b0, 3'd0, 8'd0);
    step("R3 pending fully masked", 4'h0, 1'b0, 2'd1, 4'h0, 1'b0, 3'd0, 8'd0);
    step("R6 unmask", 4'h0, 1'b1, 2'd2, 4'h2, 1'b0, 3'd0, 8'd0);
    step("R3 pending", 4'h0, 1'b0, 2'd1, 4'h0, 1'b0, 3'd0, 8'd0);
    // R4 acknowledge via pending
    step("R4 ack pend", 4'h0, 1'b1, 2'd1, 4'hF, 1'b0, 3'd0, 8'd0);
    step("R4 source cleared", 4'h0, 1'b0, 2'd0, 4'h0, 1'b0, 3'd0, 8'd0);
    // R10 event wins over acknowledge
    step("R10 setup", 4'h3, 1'b0, 2'd0, 4'h0, 1'b0, 3'd0, 8'd0);
    step("R10 collide", 4'h1, 1'b1, 2'd1, 4'h3, 1'b0, 3'd0, 8'd0);
    step("R10 event kept", 4'h0, 1'b0, 2'd0, 4'h0, 1'b0, 3'd0, 8'd0);
    // R11 unmapped address
    step("R11 write", 4'h0, 1'b1, 2'd3, 4'hF, 1'b0, 3'd0, 8'd0);
    step("R11 src unchanged", 4'h0, 1'b0, 2'd0, 4'h0, 1'b0, 3'd0, 8'd0);
    step("R11 mask unchanged", 4'h0, 1'b0, 2'd2, 4'h0, 1'b0, 3'd0, 8'd0);
    step("R11 read zero", 4'h0, 1'b0, 2'd3, 4'h0, 1'b0, 3'd0, 8'd0);
    // R7 / R8 thresholds
    step("R8 clear", 4'h0, 1'b1, 2'd0, 4'hF, 1'b0, 3'd0, 8'd0);
    probe(1'b1, 3'd3, 8'd5);
    probe(1'b1, 3'd3, 8'd7);
    probe(1'b1, 3'd3, 8'd24);
    probe(1'b1, 3'd3, 8'd25);
    probe(1'b1, 3'd0, 8'd0);
    probe(1'b0, 3'd7, 8'd0);
    probe(1'b1, 3'd7, 8'd200);
    // R9 full flag boundary
    step("R9 below", 4'h0, 1'b0, 2'd0, 4'h0, 1'b0, 3'd0, 8'd63);
    step("R9 at depth", 4'h0, 1'b0, 2'd0, 4'h0, 1'b0, 3'd0, 8'd64);
    // random traffic
    for (int i = 0; i < 400; i++) begin
      logic [3:0] re;
      re = ($urandom % 4 == 0) ? 4'($urandom) : 4'h0;
      step("R3 random read", re, 1'($urandom), 2'($urandom), 4'($urandom),
           1'($urandom), 3'($urandom), 8'($urandom % 80));
    end
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule